// File: doc/BRIEF.md
# Fixed-Order Priority Interrupt Selector

This block decides, at each instruction boundary, whether a pending device interrupt is accepted and which one. Twelve request sources feed it: a keyboard (character available), a display (ready for more data), eight general-purpose pins and two timers. Each source has a one-cycle event input. The event sets a held request flag, which carries no payload. Each source also has a fixed priority and an interrupt vector.

When the boundary input is high, the block walks the sources in a fixed order: keyboard, display, pins 0 to 7, timer 0, timer 1. It compares each source's priority with the processor's current priority level. The walk ends without a result at the first source whose priority is not above the current level, even if later sources are pending. Otherwise the first pending source reached is accepted. The result is registered. One cycle after the boundary, a take strobe appears together with the accepted vector and priority. The accepted flag is cleared at that same clock edge.

Source priorities are a parameter and must not increase along the scan order. Elaboration stops with an error if they do.

Top module: `irq_prio_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, all request flags (`pending_o`) are zero, and `take_o`, `take_vec_o` and `take_prio_o` are zero.
- R2: A high `req_i[i]` in a cycle sets flag i at the next clock edge. The flag stays set until that source is accepted. Source index i is 0 for keyboard, 1 for display, 2 to 9 for pins 0 to 7, and 10 to 11 for the timers.
- R3: Arbitration happens only in a cycle where `boundary_i` is high. Its result shows on `take_o` in the following cycle. With `boundary_i` low, `take_o` is 0 in the next cycle.
- R4: The accepted source is the lowest-index pending source whose priority is strictly greater than `cur_prio_i`.
- R5: The scan stops at the first index whose priority is less than or equal to `cur_prio_i`. No source at or beyond that index is accepted in that cycle.
- R6: With `take_o` high, `take_vec_o` equals VEC_BASE plus the accepted index and `take_prio_o` equals that source's priority. With `take_o` low, both are zero.
- R7: The accepted source's flag is zero in the cycle where `take_o` is high. Other flags are unaffected.
- R8: If a new request for a source arrives in the same cycle that the source is accepted, its flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | One-cycle request events, one bit per source |
| boundary_i | input | 1 | High in an instruction-boundary cycle |
| cur_prio_i | input | PRIO_W | Current processor priority level |
| take_o | output | 1 | Interrupt accepted (registered) |
| take_vec_o | output | VEC_W | Vector of the accepted source |
| take_prio_o | output | PRIO_W | Priority of the accepted source |
| pending_o | output | NUM_SRC | Held request flags |

## Verification
The bench uses descending priorities to aim at the early stop. With a low-priority source pending behind an equal-priority index, a design that skipped past that index instead of stopping would raise a take. With two pending sources, a design that picked by highest index or ignored priority would return the wrong vector. A request that coincides with its own acceptance is driven on purpose: a design that cleared after setting would lose that event. Long random stretches of requests, boundaries and levels are compared against a behavioural model each cycle. These catch a take without a boundary, a result that appears a cycle early or late, and clearing of the wrong flag.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned IRQ_PRIO_W_DEF = 3;
  localparam int unsigned IRQ_VEC_W_DEF  = 8;

  typedef enum int unsigned {
    SRC_KEYB  = 0,
    SRC_DISP  = 1,
    SRC_PIN0  = 2,
    SRC_TMR0  = 10,
    SRC_TMR1  = 11
  } irq_src_e;

  // vector arithmetic kept in one place
  function automatic int unsigned src_vec(input int unsigned base, input int unsigned idx);
    return base + idx;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flags_o
);
  logic [NUM_SRC-1:0] flags_q;

  // set wins over clear so a coincident event is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

  p_clear_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((flags_o & $past(clr_i) & ~$past(set_i)) == '0));

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(set_i)) == '0));

  p_single_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i));
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
  parameter int unsigned NUM_SRC = 12,
  parameter int unsigned PRIO_W  = 3,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {NUM_SRC{3'd4}},
  localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [PRIO_W-1:0]  cur_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic stop;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    stop  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!stop) begin
        if (SRC_PRIO[i*PRIO_W +: PRIO_W] <= cur_i) begin
          stop = 1'b1;                 // R5: early end of the walk
        end else if (flags_i[i]) begin
          hit_o = 1'b1;
          idx_o = IDX_W'(i);
          stop  = 1'b1;
        end
      end
    end
  end

  p_hit_is_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> flags_i[idx_o]);

  p_hit_above_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (SRC_PRIO[idx_o*PRIO_W +: PRIO_W] > cur_i));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 12,
  parameter int unsigned PRIO_W   = IRQ_PRIO_W_DEF,
  parameter int unsigned VEC_W    = IRQ_VEC_W_DEF,
  parameter logic [NUM_SRC*PRIO_W-1:0] SRC_PRIO = {NUM_SRC{3'd4}},
  parameter int unsigned VEC_BASE = 'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               boundary_i,
  input  logic [PRIO_W-1:0]  cur_prio_i,
  output logic               take_o,
  output logic [VEC_W-1:0]   take_vec_o,
  output logic [PRIO_W-1:0]  take_prio_o,
  output logic [NUM_SRC-1:0] pending_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  // elaboration check: priorities must not rise along the scan order
  for (genvar gi = 1; gi < NUM_SRC; gi++) begin : g_order
    if (SRC_PRIO[gi*PRIO_W +: PRIO_W] > SRC_PRIO[(gi-1)*PRIO_W +: PRIO_W]) begin : g_bad
      $error("irq_prio_arbiter: source priorities increase along scan order");
    end
  end

  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] clr_vec;
  logic               scan_hit;
  logic [IDX_W-1:0]   scan_idx;
  logic               grant;

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(req_i), .clr_i(clr_vec), .flags_o(flags)
  );

  irq_prio_scan #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .SRC_PRIO(SRC_PRIO)) u_scan (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .cur_i(cur_prio_i),
    .hit_o(scan_hit), .idx_o(scan_idx)
  );

  assign grant   = boundary_i & scan_hit;
  assign clr_vec = grant ? (NUM_SRC'(1) << scan_idx) : '0;

  logic              take_q;
  logic [VEC_W-1:0]  vec_q;
  logic [PRIO_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      prio_q <= '0;
    end else begin
      take_q <= grant;
      vec_q  <= grant ? VEC_W'(src_vec(VEC_BASE, 32'(scan_idx))) : '0;
      prio_q <= grant ? SRC_PRIO[scan_idx*PRIO_W +: PRIO_W] : '0;
    end
  end

  assign take_o      = take_q;
  assign take_vec_o  = vec_q;
  assign take_prio_o = prio_q;
  assign pending_o   = flags;

  p_take_needs_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));

  p_take_above_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (take_prio_o > $past(cur_prio_i)));

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (take_vec_o == '0 && take_prio_o == '0));
endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb;
  import irq_arb_pkg::*;

  localparam int N = 12;
  localparam logic [N*3-1:0] PRIOS =
    {3'd1,3'd2,3'd3,3'd3,3'd4,3'd4,3'd5,3'd5,3'd6,3'd6,3'd7,3'd7};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         bnd = 1'b0;
  logic [2:0]   cur = '0;
  logic         take;
  logic [7:0]   tvec;
  logic [2:0]   tprio;
  logic [N-1:0] pend;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(N), .SRC_PRIO(PRIOS), .VEC_BASE('h80)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .boundary_i(bnd), .cur_prio_i(cur),
    .take_o(take), .take_vec_o(tvec), .take_prio_o(tprio), .pending_o(pend)
  );

  // behavioural reference
  int           bprio [N] = '{7,7,6,6,5,5,4,4,3,3,2,1};
  bit [N-1:0]   m_flags;
  bit           m_take;
  int           m_vec, m_prio;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flags = '0; m_take = 0; m_vec = 0; m_prio = 0;
    end else begin
      int g;
      g = -1;
      if (bnd) begin
        for (int i = 0; i < N; i++) begin
          if (bprio[i] <= int'(cur)) break;
          if (m_flags[i]) begin g = i; break; end
        end
      end
      m_take = (g >= 0);
      m_vec  = (g >= 0) ? 'h80 + g : 0;
      m_prio = (g >= 0) ? bprio[g] : 0;
      if (g >= 0) m_flags[g] = 1'b0;
      m_flags = m_flags | req;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3/R4 take vs model", int'(take), int'(m_take));
      chk("R6 vector vs model", int'(tvec), m_vec);
      chk("R6 priority vs model", int'(tprio), m_prio);
      chk("R2/R7/R8 flags vs model", int'(pend), int'(m_flags));
    end
  end

  task automatic step(input logic [N-1:0] r, input logic b, input logic [2:0] c);
    #1; req = r; bnd = b; cur = c;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", int'(pend), 0);
    chk("R1 take in reset", int'(take), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 take after reset", int'(take), 0);
    chk("R1 vector after reset", int'(tvec), 0);
    chk("R1 pending after reset", int'(pend), 0);
    cmp_on = 1'b1;

    // R2 and R3: flag held, nothing taken without a boundary
    step(N'(1) << 5, 0, 3);
    chk("R2 flag set", int'(pend[5]), 1);
    step('0, 0, 3);
    step('0, 0, 3);
    chk("R2 flag held", int'(pend[5]), 1);
    chk("R3 no take without boundary", int'(take), 0);

    // R4 R6 R7: accept source 5
    step('0, 1, 3);
    chk("R3 take after boundary", int'(take), 1);
    chk("R6 vector 0x85", int'(tvec), 'h85);
    chk("R6 priority 5", int'(tprio), 5);
    chk("R7 flag cleared", int'(pend[5]), 0);
    step('0, 0, 3);
    chk("R3 take one cycle", int'(take), 0);

    // R5: stop at index 8 (prio 3 <= 3) though 8 and 11 pend
    step((N'(1) << 8) | (N'(1) << 11), 0, 3);
    step('0, 1, 3);
    chk("R5 early stop no take", int'(take), 0);
    chk("R5 flags untouched", int'(pend), 'h900);

    // R4: lowest pending index wins
    step((N'(1) << 3) | (N'(1) << SRC_TMR0 - 1), 0, 0);
    step('0, 1, 0);
    chk("R4 lowest index taken", int'(tvec), 'h83);
    chk("R4 priority of index 3", int'(tprio), 6);
    chk("R7 others kept", int'(pend), 'hB00);

    // R8: coincident request on the accepted source
    step(N'(1) << 8, 1, 0);
    chk("R8 take vector 0x88", int'(tvec), 'h88);
    chk("R8 flag kept", int'(pend[8]), 1);

    step('0, 1, 0);
    step('0, 1, 0);
    step('0, 1, 0);
    step('0, 1, 0);
    chk("R7 drained", int'(pend), 0);

    // random stretch against the model
    for (int k = 0; k < 4000; k++) begin
      step(N'($urandom & $urandom & $urandom), 1'($urandom), 3'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule